// File: doc/BRIEF.md
# Byte-Lane Bus Cycle Controller

This block runs the external read and write cycles of a 16-bit processor core on a 24-bit address bus with a 16-bit data bus. The core hands it one request at a time through a valid/ready handshake: an address, a byte or word size, a direction, a lock flag and write data. The block latches the request and runs the bus cycle. It drives the address, the low-bank select (address bit 0) and the active-low high-byte enable. It also drives an address strobe and active-low read and write strobes, and it returns read data to the core.

The input clock is halved internally. All cycle state advances only on the processor-clock tick, which falls on every second input clock. Each cycle spends one processor clock in an address phase and at least one in a data phase. An active-low ready input, sampled at the end of the data phase, adds wait states. That input is ignored while hold acknowledge is high. A locked request keeps the active-low lock output asserted through its own cycle and the cycle that follows it. After reset, no request is accepted until 38 processor clocks have elapsed. Word requests are always run aligned.

Top module: `lane_bus_ctrl`

## Requirements
- R1: The input clock is divided by two. `pclk_ph` alternates every input clock, so every strobe phase lasts an even number of input clocks.
- R2: After reset is released, `req_ready` stays low for at least 38 processor clocks (76 input clocks). It rises no later than 80 input clocks after release.
- R3: A byte request at an even address drives bit 0 of `bus_addr` to 0 and `bhe_n` to 1. A read returns `bus_din[7:0]` in `rsp_rdata[7:0]`, with bits 15..8 cleared.
- R4: A byte request at an odd address drives bit 0 of `bus_addr` to 1 and `bhe_n` to 0. A write presents the byte `req_wdata[7:0]` on both `bus_dout[15:8]` and `bus_dout[7:0]`. A read returns `bus_din[15:8]` in `rsp_rdata[7:0]`, with bits 15..8 cleared.
- R5: A word request drives bit 0 of `bus_addr` to 0 and `bhe_n` to 0 whatever bit 0 of its address is. It transfers all 16 data bits unchanged.
- R6: `ads_n` is low for exactly one processor clock (2 input clocks) per cycle. The read or write strobe follows at once.
- R7: With ready held high for N sampling points, the strobe stays low for 2*(N+1) input clocks. During a write, `bus_doe` is 1. During a read, `bus_doe` is 0.
- R8: While `hlda` is 1, no request is accepted and a data phase does not end, even with `rdy_n` low.
- R9: `lock_n` is low from the address phase of a locked cycle until the end of the next cycle. It is high otherwise.
- R10: During reset, `req_ready`, `rsp_valid` and all strobes are inactive. `req_ready` is low while a cycle is in progress. A pending request waits until it is accepted.
- R11: Bits 23..1 of `bus_addr` carry bits 23..1 of the request address. `rsp_valid` pulses for one input clock at the end of every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock (twice the processor rate) |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Request accepted on this edge |
| req_addr | input | 24 | Request byte address |
| req_word | input | 1 | 1 = word transfer, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lock | input | 1 | Lock this cycle and the next |
| req_wdata | input | 16 | Write data (byte in bits 7..0) |
| rsp_valid | output | 1 | Cycle completed pulse |
| rsp_rdata | output | 16 | Read data, byte right-aligned |
| bus_addr | output | 24 | Bus address including bit 0 |
| bhe_n | output | 1 | High-byte enable, active low |
| ads_n | output | 1 | Address strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| lock_n | output | 1 | Bus lock, active low |
| bus_dout | output | 16 | Write data to bus |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | 16 | Read data from bus |
| rdy_n | input | 1 | Ready, active low |
| hlda | input | 1 | Hold acknowledge |
| pclk_ph | output | 1 | Processor-clock tick phase |

## Verification
On every cycle, the assertions check the following:
- the tick alternates;
- ready is held low during the startup delay and during a cycle;
- the address strobe lasts at least one processor clock;
- a data phase cannot end while ready is high or hold acknowledge is active;
- lock is released only after a completed cycle.

Only the bench scenarios show the exact data steering and lane encoding over all combinations of size, address parity and direction. The same applies to the exact strobe lengths for a given wait-state count, the exact startup delay window, and the lock span across a locked-then-unlocked sequence.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

  localparam int DW = 16;
  localparam int BW = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } cyc_state_t;

  // low-bank select: words always run aligned
  function automatic logic lane_a0(input logic word, input logic a0);
    return word ? 1'b0 : a0;
  endfunction

  // high-byte enable, active low: word or odd byte uses bits 15..8
  function automatic logic lane_bhe_n(input logic word, input logic a0);
    return !(word || a0);
  endfunction

  // byte writes are replicated onto both lanes
  function automatic logic [DW-1:0] steer_wr(input logic word, input logic [DW-1:0] w);
    return word ? w : {w[BW-1:0], w[BW-1:0]};
  endfunction

  // byte reads are right-aligned from the lane selected by a0
  function automatic logic [DW-1:0] steer_rd(input logic word, input logic a0,
                                              input logic [DW-1:0] d);
    logic [DW-1:0] r;
    if (word)    r = d;
    else if (a0) r = {{(DW-BW){1'b0}}, d[DW-1:BW]};
    else         r = {{(DW-BW){1'b0}}, d[BW-1:0]};
    return r;
  endfunction

endpackage

// File: rtl/lbc_clkdiv.sv
module lbc_clkdiv (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic ph;

  always_ff @(posedge clk) begin
    if (rst) ph <= 1'b0;
    else     ph <= !ph;
  end

  assign tick = ph;

  a_r1_tick_falls: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
  a_r1_tick_rises: assert property (@(posedge clk) disable iff (rst) !tick |=> tick);
endmodule

// File: rtl/lbc_boot.sv
module lbc_boot #(
  parameter int BOOT_CLKS = 38
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic boot_done
);
  localparam int CW = $clog2(BOOT_CLKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(BOOT_CLKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (tick && cnt < LIMIT) cnt <= cnt + 1'b1;
  end

  assign boot_done = (cnt == LIMIT);

  a_r2_done_sticky: assert property (@(posedge clk) disable iff (rst) boot_done |=> boot_done);
endmodule

// File: rtl/lbc_lock.sv
module lbc_lock (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic start_lock,
  input  logic done,
  output logic lock_n
);
  // number of cycle completions still covered by the lock
  logic [1:0] left;

  always_ff @(posedge clk) begin
    if (rst)                       left <= 2'd0;
    else if (start && start_lock)  left <= 2'd2;
    else if (done && left != 2'd0) left <= left - 2'd1;
  end

  assign lock_n = (left == 2'd0);

  a_r9_release_after_done: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_n) |-> $past(done));
  a_r9_no_lock_in_idle_start: assert property (@(posedge clk) disable iff (rst)
    (start && start_lock) |=> !lock_n);
endmodule

// File: rtl/lbc_seq.sv
module lbc_seq
  import lbc_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          boot_done,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_word,
  input  logic          req_write,
  input  logic          req_lock,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] bus_addr,
  output logic          bhe_n,
  output logic          ads_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [DW-1:0] bus_din,
  input  logic          rdy_n,
  input  logic          hlda,
  output logic          start,
  output logic          start_lock,
  output logic          cyc_done
);
  cyc_state_t    state;
  logic [AW-1:0] lat_addr;
  logic          lat_word;
  logic          lat_write;
  logic [DW-1:0] lat_wdata;
  logic          in_data;
  logic          lane0;

  assign in_data    = (state == ST_DATA);
  assign req_ready  = (state == ST_IDLE) && boot_done && !hlda && tick;
  assign start      = req_valid && req_ready;
  assign start_lock = req_lock;
  // ready is ignored while hold acknowledge is high
  assign cyc_done   = in_data && tick && !rdy_n && !hlda;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      lat_addr  <= '0;
      lat_word  <= 1'b0;
      lat_write <= 1'b0;
      lat_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state     <= ST_ADDR;
          lat_addr  <= req_addr;
          lat_word  <= req_word;
          lat_write <= req_write;
          lat_wdata <= req_wdata;
        end
        ST_ADDR: if (tick) state <= ST_DATA;
        ST_DATA: if (cyc_done) begin
          state     <= ST_IDLE;
          rsp_valid <= 1'b1;
          rsp_rdata <= lat_write ? '0 : steer_rd(lat_word, lane0, bus_din);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign lane0    = lane_a0(lat_word, lat_addr[0]);
  assign bus_addr = {lat_addr[AW-1:1], lane0};
  assign bhe_n    = (state == ST_IDLE) ? 1'b1 : lane_bhe_n(lat_word, lat_addr[0]);
  assign ads_n    = !(state == ST_ADDR);
  assign rd_n     = !(in_data && !lat_write);
  assign wr_n     = !(in_data && lat_write);
  assign bus_doe  = (state != ST_IDLE) && lat_write;
  assign bus_dout = steer_wr(lat_word, lat_wdata);

  a_r10_busy_no_ready: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> !req_ready);
  a_r6_addr_two_clks: assert property (@(posedge clk) disable iff (rst)
    $fell(ads_n) |=> !ads_n);
  a_r7_wait_holds_data: assert property (@(posedge clk) disable iff (rst)
    (in_data && tick && rdy_n) |=> in_data);
  a_r8_hlda_blocks_end: assert property (@(posedge clk) disable iff (rst)
    (in_data && hlda) |=> in_data);
  a_r8_hlda_no_accept: assert property (@(posedge clk) disable iff (rst)
    hlda |-> !req_ready);
  a_r5_word_aligned: assert property (@(posedge clk) disable iff (rst)
    (!ads_n && lat_word) |-> (!bus_addr[0] && !bhe_n));
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/lane_bus_ctrl.sv
module lane_bus_ctrl
  import lbc_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int BOOT_CLKS = 38
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              req_write,
  input  logic              req_lock,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bhe_n,
  output logic              ads_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              lock_n,
  output logic [15:0]       bus_dout,
  output logic              bus_doe,
  input  logic [15:0]       bus_din,
  input  logic              rdy_n,
  input  logic              hlda,
  output logic              pclk_ph
);
  logic tick, boot_done, start, start_lock, cyc_done;

  lbc_clkdiv u_div (.clk(clk), .rst(rst), .tick(tick));

  lbc_boot #(.BOOT_CLKS(BOOT_CLKS)) u_boot (
    .clk(clk), .rst(rst), .tick(tick), .boot_done(boot_done));

  lbc_seq #(.AW(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .boot_done(boot_done),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_word(req_word), .req_write(req_write), .req_lock(req_lock),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bhe_n(bhe_n), .ads_n(ads_n), .rd_n(rd_n), .wr_n(wr_n),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .rdy_n(rdy_n), .hlda(hlda),
    .start(start), .start_lock(start_lock), .cyc_done(cyc_done));

  lbc_lock u_lock (
    .clk(clk), .rst(rst), .start(start), .start_lock(start_lock),
    .done(cyc_done), .lock_n(lock_n));

  assign pclk_ph = tick;

  a_r2_hold_off: assert property (@(posedge clk) disable iff (rst)
    !boot_done |-> !req_ready);
  a_r6_strobe_follows: assert property (@(posedge clk) disable iff (rst)
    $rose(ads_n) |-> (!rd_n || !wr_n));
  a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    $countones({!ads_n, !rd_n, !wr_n}) <= 1);
endmodule

// File: tb/tb_lane_bus_ctrl.sv
module tb_lane_bus_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_word, req_write, req_lock;
  logic        req_ready, rsp_valid;
  logic [23:0] req_addr, bus_addr;
  logic [15:0] req_wdata, rsp_rdata, bus_dout, bus_din;
  logic        bhe_n, ads_n, rd_n, wr_n, lock_n, bus_doe, rdy_n, hlda, pclk_ph;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = !clk;

  lane_bus_ctrl dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_word(req_word), .req_write(req_write),
    .req_lock(req_lock), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bhe_n(bhe_n), .ads_n(ads_n),
    .rd_n(rd_n), .wr_n(wr_n), .lock_n(lock_n), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din), .rdy_n(rdy_n), .hlda(hlda),
    .pclk_ph(pclk_ph));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one bus cycle; nw = wait states, hld = strobe clocks with hold acknowledge high
  task automatic run_cycle(input logic [23:0] a, input bit w, input bit wr, input bit lk,
                           input logic [15:0] wd, input int nw, input int hld,
                           input bit exp_lock_low);
    int sc = 0, ac = 0, guard = 0;
    bit seen_lock = 0, dchk = 0;
    logic [15:0] din_v = a[15:0] ^ 16'h5A3C;
    int k;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_word = w; req_write = wr; req_lock = lk;
    req_wdata = wd; bus_din = din_v;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    guard = 0;
    while (!rsp_valid && guard < 200) begin
      if (!ads_n) begin
        ac++;
        if (ac == 1) begin
          // R11 upper address, R3/R4/R5 lane codes
          chk(bus_addr[23:1] == a[23:1], "R11 addr", bus_addr, a);
          chk(bus_addr[0] == (w ? 1'b0 : a[0]), "R3/R5 a0", bus_addr[0], w ? 0 : a[0]);
          chk(bhe_n == !(w || a[0]), "R4 bhe_n", bhe_n, !(w || a[0]));
          chk(lock_n == !exp_lock_low, "R9 lock_n", lock_n, !exp_lock_low);
          seen_lock = 1;
        end
      end
      if (!rd_n || !wr_n) begin
        sc++;
        rdy_n = (sc < 2*nw + 1);
        hlda  = (sc <= hld);
        if (!dchk) begin
          dchk = 1;
          chk(bus_doe == wr, "R7 doe", bus_doe, wr);
          if (wr) chk(bus_dout == (w ? wd : {wd[7:0], wd[7:0]}), "R4 dout",
                      bus_dout, w ? wd : {wd[7:0], wd[7:0]});
        end
      end
      @(negedge clk);
      guard++;
    end
    rdy_n = 1; hlda = 0;
    chk(rsp_valid, "R11 rsp_valid", rsp_valid, 1);
    chk(ac == 2, "R6 ads length", ac, 2);
    k = (nw + 1 > hld/2 + 1) ? nw + 1 : hld/2 + 1;
    chk(sc == 2*k, "R7 strobe length", sc, 2*k);
    if (!wr) begin
      logic [15:0] er;
      er = w ? din_v : (a[0] ? {8'h00, din_v[15:8]} : {8'h00, din_v[7:0]});
      chk(rsp_rdata == er, "R3 rdata", rsp_rdata, er);
    end
    @(negedge clk);
    chk(!rsp_valid, "R11 pulse", rsp_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] addrs [5];
    int cnt;
    addrs[0] = 24'h000000; addrs[1] = 24'hABCDE1; addrs[2] = 24'hFFFFFF;
    addrs[3] = 24'h123456; addrs[4] = 24'h800001;
    rst = 1; req_valid = 0; req_addr = 0; req_word = 0; req_write = 0; req_lock = 0;
    req_wdata = 0; bus_din = 0; rdy_n = 1; hlda = 0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(!req_ready && !rsp_valid, "R10 reset ready", req_ready, 0);
    chk(ads_n && rd_n && wr_n && lock_n, "R10 reset strobes", {ads_n, rd_n, wr_n, lock_n}, 4'hF);
    rst = 0;
    req_valid = 1;
    // R2 startup delay, R10 stalled request
    cnt = 0;
    while (!req_ready && cnt < 200) begin
      @(negedge clk); cnt++;
      chk(ads_n, "R10 stalled", ads_n, 1);
    end
    chk(cnt >= 76 && cnt <= 80, "R2 boot delay", cnt, 76);
    req_valid = 0;
    // R1 phase alternates
    for (int i = 0; i < 6; i++) begin
      logic p;
      p = pclk_ph;
      @(negedge clk);
      chk(pclk_ph == !p, "R1 phase", pclk_ph, !p);
    end
    // sweep: size, parity, direction, wait states
    for (int ai = 0; ai < 5; ai++)
      for (int wv = 0; wv < 2; wv++)
        for (int dv = 0; dv < 2; dv++)
          for (int nw = 0; nw < 3; nw++)
            run_cycle(addrs[ai], wv[0], dv[0], 1'b0,
                      16'hC3A5 ^ 16'(ai * 257 + nw), nw, 0, 1'b0);
    // R8 hold acknowledge blocks acceptance
    @(negedge clk);
    hlda = 1; req_valid = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!req_ready && ads_n, "R8 no accept", req_ready, 0);
    end
    hlda = 0; req_valid = 0;
    // R8 hold acknowledge stretches data phase though ready is low
    run_cycle(24'h004321, 1'b1, 1'b0, 1'b0, 16'h0, 0, 5, 1'b0);
    run_cycle(24'h004322, 1'b0, 1'b1, 1'b0, 16'h7E81, 1, 6, 1'b0);
    // R9 lock spans locked cycle and the next
    run_cycle(24'h000100, 1'b1, 1'b0, 1'b1, 16'h0, 0, 0, 1'b1);
    @(negedge clk);
    chk(!lock_n, "R9 lock held idle", lock_n, 0);
    run_cycle(24'h000103, 1'b0, 1'b1, 1'b0, 16'h00AB, 1, 0, 1'b1);
    @(negedge clk);
    chk(lock_n, "R9 lock released", lock_n, 1);
    run_cycle(24'h000104, 1'b0, 1'b0, 1'b0, 16'h0, 0, 0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule